// File: doc/BRIEF.md
# Security-Banked Configuration Register

This block holds one 32-bit configuration word for each of two security states, Secure and Non-secure, on a small register bus. Each access carries a secure attribute. That attribute picks the copy that a read returns or that a write updates. The register decodes a single word offset, 0xD14, in the system control space. Reads are combinational, and writes take effect at the next clock edge.

Two control bits are shared by both states. Each shared bit is kept in only one of the two copies. The fault-ignore bit lives in the Non-secure copy, and either state can write it and read it. The secure stack-check bit lives in the Secure copy. It can be written only by a Secure access, and only when the v8.1 feature input is high. A Non-secure access always reads it as zero.

Three static feature inputs set the behaviour. The mainline input makes the offset decodable at all. The v8 input forces two bits to one. The v8.1 input makes the stack-check bit writable. Both stored copies are driven out as ports so that nearby logic can use them.

Top module: `banked_cfg_reg`

## Requirements
- R1: While rstN is low, both stored copies clear to zero. When featV8 is high, bits 0 and 9 of both copies reset to one instead.
- R2: With featMain low, a read or write at offset 0xD14 raises regErr in the same cycle. The read data is zero and a write changes nothing. An access to any other offset never raises regErr, reads zero and changes nothing.
- R3: With featMain high, a write at 0xD14 changes only the copy picked by regSecure (1 = Secure, 0 = Non-secure). The one exception is the shared bit 8 described in R5.
- R4: A write can change only these bits: 0 (any-level thread entry), 1 (user pend), 3 (unaligned trap), 4 (divide-by-zero trap), 8 (fault ignore), 9 (stack align), and 20 when R6 allows it. Every other bit of both copies stays zero.
- R5: Bit 8 is shared and stored only in the Non-secure copy. A write from either state sets its value. A read from either state returns it. Bit 8 of the Secure copy stays zero.
- R6: Bit 20 is stored only in the Secure copy. It is written only by a Secure write while featV81 is high. A Non-secure read returns 0 in bit 20, and a Non-secure write never changes it.
- R7: While featV8 is high, bits 0 and 9 read as one in both copies, whatever data is written.
- R8: A read while regRd is high returns the stored value from before any write in the same cycle. The write shows at the next clock edge.
- R9: cfgSec and cfgNs always present the stored Secure and Non-secure copies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featMain | input | 1 | Mainline feature present; the offset is decoded only when high |
| featV8 | input | 1 | v8 feature present; forces bits 0 and 9 to one |
| featV81 | input | 1 | v8.1 feature present; makes bit 20 writable from Secure |
| regAddr | input | 12 | Word offset within the system control space |
| regWr | input | 1 | Write enable |
| regRd | input | 1 | Read enable |
| regSecure | input | 1 | Secure attribute of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational |
| regErr | output | 1 | Invalid-offset indication |
| cfgSec | output | 32 | Stored Secure copy |
| cfgNs | output | 32 | Stored Non-secure copy |

## Verification
A read and a write can fall in the same cycle. A Secure write can also update both copies in that same cycle, because bit 8 goes to the Non-secure copy and the rest goes to the Secure copy. The bench drives random reads and writes together under every feature setting and with both attribute values. It checks that each read returns the value the model held before the edge. At the following edge it checks both exported copies against the model, including the split of a Secure write across the two copies.

// File: rtl/banked_cfg_pkg.sv
package banked_cfg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam logic [ADDR_W-1:0] REG_OFFSET = 12'hD14;

  // field positions within the configuration word
  localparam int BIT_THREAD_ANY  = 0;
  localparam int BIT_USER_PEND   = 1;
  localparam int BIT_UNALIGN_TRP = 3;
  localparam int BIT_DIV0_TRP    = 4;
  localparam int BIT_FAULT_IGN   = 8;
  localparam int BIT_STACK_ALIGN = 9;
  localparam int BIT_SEC_CHECK   = 20;

  localparam logic [DATA_W-1:0] ONE_W = {{(DATA_W-1){1'b0}}, 1'b1};

  localparam logic [DATA_W-1:0] BASE_MASK =
      (ONE_W << BIT_THREAD_ANY) | (ONE_W << BIT_USER_PEND) |
      (ONE_W << BIT_UNALIGN_TRP) | (ONE_W << BIT_DIV0_TRP) |
      (ONE_W << BIT_FAULT_IGN) | (ONE_W << BIT_STACK_ALIGN);
  localparam logic [DATA_W-1:0] SHARED_NS_MASK = ONE_W << BIT_FAULT_IGN;
  localparam logic [DATA_W-1:0] SEC_ONLY_MASK  = ONE_W << BIT_SEC_CHECK;
  localparam logic [DATA_W-1:0] FORCE_MASK =
      (ONE_W << BIT_THREAD_ANY) | (ONE_W << BIT_STACK_ALIGN);

  typedef struct packed {
    logic wrSec;     // commit a Secure write
    logic wrNs;      // commit a Non-secure write
    logic rdValid;   // present read data
    logic rdSec;     // read selects the Secure copy
    logic secChkOk;  // bit 20 may be written
    logic forceOne;  // forced-one bits active
  } ctrlStrobeT;
endpackage

// File: rtl/banked_cfg_ctrl.sv
module banked_cfg_ctrl
  import banked_cfg_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter logic [ADDR_BITS-1:0] OFFSET = REG_OFFSET
) (
  input  logic                 featMain,
  input  logic                 featV8,
  input  logic                 featV81,
  input  logic [ADDR_BITS-1:0] regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic                 regSecure,
  output logic                 regErr,
  output ctrlStrobeT           strb
);
  logic addrHit;
  logic decoded;

  always_comb begin
    addrHit       = (regAddr == OFFSET);
    decoded       = addrHit && featMain;
    regErr        = addrHit && !featMain && (regRd || regWr);
    strb.wrSec    = regWr && decoded && regSecure;
    strb.wrNs     = regWr && decoded && !regSecure;
    strb.rdValid  = regRd && decoded;
    strb.rdSec    = regSecure;
    strb.secChkOk = featV81 && regSecure;
    strb.forceOne = featV8;
  end
endmodule

// File: rtl/banked_cfg_dp.sv
module banked_cfg_dp
  import banked_cfg_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strb,
  input  logic [WIDTH-1:0] regWdata,
  output logic [WIDTH-1:0] regRdata,
  output logic [WIDTH-1:0] secQ,
  output logic [WIDTH-1:0] nsQ
);
  localparam logic [WIDTH-1:0] BaseM   = WIDTH'(BASE_MASK);
  localparam logic [WIDTH-1:0] SharedM = WIDTH'(SHARED_NS_MASK);
  localparam logic [WIDTH-1:0] SecM    = WIDTH'(SEC_ONLY_MASK);
  localparam logic [WIDTH-1:0] ForceM  = WIDTH'(FORCE_MASK);

  logic [WIDTH-1:0] wrMask;
  logic [WIDTH-1:0] wrVal;
  logic [WIDTH-1:0] forceBits;
  logic [WIDTH-1:0] selCopy;

  always_comb begin
    forceBits = strb.forceOne ? ForceM : '0;
    wrMask    = BaseM | (strb.secChkOk ? SecM : '0);
    wrVal     = (regWdata & wrMask) | forceBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ <= forceBits;
      nsQ  <= forceBits;
    end else if (strb.wrSec) begin
      secQ <= wrVal & ~SharedM;
      nsQ  <= (nsQ & ~SharedM) | (wrVal & SharedM);
    end else if (strb.wrNs) begin
      nsQ  <= wrVal;
    end
  end

  always_comb begin
    selCopy  = strb.rdSec ? secQ : nsQ;
    regRdata = strb.rdValid ? (selCopy | (nsQ & SharedM)) : '0;
  end
endmodule

// File: rtl/banked_cfg_reg.sv
module banked_cfg_reg
  import banked_cfg_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int ADDR_BITS = ADDR_W,
  parameter logic [ADDR_BITS-1:0] OFFSET = REG_OFFSET
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 featMain,
  input  logic                 featV8,
  input  logic                 featV81,
  input  logic [ADDR_BITS-1:0] regAddr,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic                 regSecure,
  input  logic [WIDTH-1:0]     regWdata,
  output logic [WIDTH-1:0]     regRdata,
  output logic                 regErr,
  output logic [WIDTH-1:0]     cfgSec,
  output logic [WIDTH-1:0]     cfgNs
);
  ctrlStrobeT strb;

  banked_cfg_ctrl #(.ADDR_BITS(ADDR_BITS), .OFFSET(OFFSET)) u_ctrl (
    .featMain (featMain),
    .featV8   (featV8),
    .featV81  (featV81),
    .regAddr  (regAddr),
    .regWr    (regWr),
    .regRd    (regRd),
    .regSecure(regSecure),
    .regErr   (regErr),
    .strb     (strb)
  );

  banked_cfg_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .secQ    (cfgSec),
    .nsQ     (cfgNs)
  );
endmodule

// File: rtl/banked_cfg_checker.sv
module banked_cfg_checker
  import banked_cfg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              featMain,
  input logic              featV8,
  input logic              featV81,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWr,
  input logic              regRd,
  input logic              regSecure,
  input logic [DATA_W-1:0] regWdata,
  input logic [DATA_W-1:0] regRdata,
  input logic              regErr,
  input logic [DATA_W-1:0] cfgSec,
  input logic [DATA_W-1:0] cfgNs
);
  logic hitLive;
  assign hitLive = (regAddr == REG_OFFSET) && featMain;

  p_err_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((regAddr == REG_OFFSET) && !featMain && (regRd || regWr)) |-> regErr);

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && hitLive) |=> ($stable(cfgSec) && $stable(cfgNs)));

  p_ns_write_keeps_sec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && hitLive && !regSecure) |=> $stable(cfgSec));

  p_reserved_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgSec & ~(BASE_MASK | SEC_ONLY_MASK)) == '0) &&
    ((cfgNs & ~BASE_MASK) == '0));

  p_shared_in_ns_r5: assert property (@(posedge clk) disable iff (!rstN)
    !cfgSec[BIT_FAULT_IGN]);

  p_ns_read_hides_r6: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && !regSecure) |-> !regRdata[BIT_SEC_CHECK]);

  p_sec_check_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(regWr && hitLive && regSecure && featV81) |=> $stable(cfgSec[BIT_SEC_CHECK]));

  p_forced_ones_r7: assert property (@(posedge clk) disable iff (!rstN)
    featV8 |-> (cfgSec[BIT_THREAD_ANY] && cfgSec[BIT_STACK_ALIGN] &&
                cfgNs[BIT_THREAD_ANY] && cfgNs[BIT_STACK_ALIGN]));
endmodule

bind banked_cfg_reg banked_cfg_checker u_chk (.*);

// File: tb/sim_banked_cfg_reg.sv
module sim_banked_cfg_reg;
  localparam logic [11:0] OFF = 12'hD14;
  localparam logic [31:0] BASE = 32'h0000_031B;
  localparam logic [31:0] SHR  = 32'h0000_0100;
  localparam logic [31:0] SCHK = 32'h0010_0000;
  localparam logic [31:0] FRC  = 32'h0000_0201;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic featMain = 1'b0, featV8 = 1'b0, featV81 = 1'b0;
  logic [11:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0, regSecure = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata, cfgSec, cfgNs;
  logic regErr;

  int total = 0;
  int bad = 0;
  logic [31:0] expS, expN;

  always #5 clk = ~clk;

  banked_cfg_reg u0 (
    .clk(clk), .rstN(rstN), .featMain(featMain), .featV8(featV8),
    .featV81(featV81), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regSecure(regSecure), .regWdata(regWdata), .regRdata(regRdata),
    .regErr(regErr), .cfgSec(cfgSec), .cfgNs(cfgNs)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(logic sec);
    return (sec ? expS : expN) | (expN & SHR);
  endfunction

  function automatic logic [31:0] maskedVal(logic sec, logic [31:0] d);
    logic [31:0] m;
    m = BASE | ((featV81 && sec) ? SCHK : 32'h0);
    return (d & m) | (featV8 ? FRC : 32'h0);
  endfunction

  task automatic modelWrite(logic sec, logic [31:0] d);
    logic [31:0] v;
    v = maskedVal(sec, d);
    if (sec) begin
      expN = (expN & ~SHR) | (v & SHR);
      expS = v & ~SHR;
    end else begin
      expN = v;
    end
  endtask

  // one bus cycle; read data is judged before the edge, copies at next op
  task automatic op(logic [11:0] a, logic wr, logic rd, logic sec,
                    logic [31:0] d, string tag);
    logic hit;
    @(negedge clk);
    chk("R9 secure copy", cfgSec, expS);
    chk("R9 non-secure copy", cfgNs, expN);
    regAddr = a; regWr = wr; regRd = rd; regSecure = sec; regWdata = d;
    #3;
    hit = (a == OFF);
    chk({"R2 err ", tag}, {31'b0, regErr},
        {31'b0, hit && !featMain && (rd || wr)});
    chk({"R8 read ", tag}, regRdata,
        (rd && hit && featMain) ? modelRead(sec) : 32'h0);
    if (wr && hit && featMain) modelWrite(sec, d);
  endtask

  task automatic doReset(logic m, logic v8, logic v81);
    @(negedge clk);
    rstN = 1'b0; regWr = 0; regRd = 0;
    featMain = m; featV8 = v8; featV81 = v81;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expS = v8 ? FRC : 32'h0;
    expN = expS;
    chk("R1 reset secure", cfgSec, expS);
    chk("R1 reset non-secure", cfgNs, expN);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int f = 0; f < 8; f++) begin
      doReset(f[0], f[1], f[2]);
      op(OFF, 0, 1, 1, 0, "R1 reset read S");
      op(OFF, 0, 1, 0, 0, "R1 reset read NS");
      for (int i = 0; i < 400; i++) begin
        logic [11:0] a;
        logic [31:0] d;
        a = ($urandom % 5 == 0) ? 12'($urandom) : OFF;
        d = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
        op(a, 1'($urandom), 1'($urandom), 1'($urandom), d, "R3 random");
      end
    end
    // directed corners with every feature on
    doReset(1, 1, 1);
    op(OFF, 1, 0, 1, SCHK, "R6 secure sets bit20");
    op(OFF, 0, 1, 0, 0, "R6 ns read hides bit20");
    op(OFF, 1, 0, 0, 32'hFFFF_FFFF, "R6 ns write all ones");
    op(OFF, 0, 1, 1, 0, "R6 secure still sees bit20");
    chk("R6 stored bit20", {31'b0, cfgSec[20]}, 32'h1);
    op(OFF, 1, 0, 0, SHR, "R5 ns writes shared");
    op(OFF, 0, 1, 1, 0, "R5 secure sees shared");
    op(OFF, 1, 0, 1, 32'h0, "R5 secure clears shared");
    op(OFF, 0, 1, 0, 0, "R5 ns sees cleared");
    op(OFF, 1, 0, 1, 32'h0, "R7 write zero");
    op(OFF, 0, 1, 1, 0, "R7 forced ones");
    op(OFF, 1, 1, 0, 32'h18, "R8 same-cycle read old");
    op(OFF, 0, 1, 0, 0, "R8 new value");
    op(OFF, 1, 0, 1, 32'hFFEF_FCE4, "R4 reserved only");
    op(OFF, 0, 1, 1, 0, "R4 reserved read");
    // secure write of bit 20 without v8.1
    doReset(1, 0, 0);
    op(OFF, 1, 0, 1, 32'hFFFF_FFFF, "R6 no v8.1");
    op(OFF, 0, 1, 1, 0, "R6 bit20 stays zero");
    op(OFF, 0, 0, 0, 0, "R9 final");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule